// File: doc/BRIEF.md
# Divisible-by-three reduction tree

This block decides, with no clock and no stored state, whether an unsigned input word of parameterised width is an exact multiple of three. Because four leaves a remainder of one when divided by three, the word can be read as a string of base-four digits (two-bit groups), and its remainder modulo three equals the remainder of the sum of those digits. The block therefore cuts the input into two-bit groups, starting from the least significant end. Each group is a small residue code. Adjacent codes are merged layer by layer in a balanced tree of modulo-three adders, so the depth grows with the logarithm of the width rather than with the width itself.

Each merge first turns both operand codes into a pair of one-hot flags, "remainder one" and "remainder two", and then forms the sum code from AND, XOR and OR terms. When a layer holds an odd number of codes, the highest one is forwarded unchanged to the next layer. An odd input width is padded with a zero above the most significant bit. The single output compares the two bits of the final code; equal bits mean remainder zero.

The block is meant to be dropped into a wider datapath wherever a divisibility test by three is needed within one combinational path, for any width from one bit upward.

Top module: `div3_detect`

## Requirements
- R1: For every width, `is_multiple` is 1 exactly when the unsigned value on `din` is divisible by three, and 0 otherwise.
- R2: A two-bit residue code {upper, lower} means remainder 0 for 00 and 11, 1 for 01 and 2 for 10. At width 2, inputs 0 and 3 give `is_multiple` = 1, and inputs 1 and 2 give 0. The final code of the tree encodes `din` mod 3 in this way.
- R3: At an odd width, the top group holds only the most significant input bit in its lower position, with a zero above it. For example, at width 5 the value 16 gives 0 and the value 24 gives 1.
- R4: An all-zero input gives `is_multiple` = 1 at every width.
- R5: At width 1, `is_multiple` is the inverse of `din[0]`.
- R6: An all-ones input gives `is_multiple` = 1 exactly when the width is even.
- R7: When a layer of the tree holds an odd number of codes (3, 6 or 17 groups, for example), the leftover code is forwarded unchanged and the verdict still follows R1.
- R8: The output is a pure combinational function of `din`. It settles within the same time step as an input change, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Unsigned word under test |
| is_multiple | output | 1 | High when `din` is a multiple of three |

## Verification
The two functions that can meet in one evaluation are the zero-padding of an odd width and the forwarding of a leftover code when a layer has an odd count. At width 5 the padded top group is itself the leftover in the first layer, and at width 7 it is merged with another group instead. Both widths are swept over every input value, and width 33 receives random words. Each result is judged against the remainder of the value divided by three, computed arithmetically in the bench, with the all-ones and single-top-bit patterns called out separately.

// File: rtl/div3_pkg.sv
package div3_pkg;

   // Running residue code of one base-four digit or partial sum.
   typedef struct packed {
      logic h;
      logic l;
   } res_t;

   // One-hot form of a residue: remainder one / remainder two.
   typedef struct packed {
      logic two;
      logic one;
   } hot_t;

   // Number of residue codes alive after k merge layers.
   function automatic int layer_count(int pairs, int k);
      int n;
      n = pairs;
      for (int i = 0; i < k; i++) n = (n + 1) / 2;
      return n;
   endfunction

   // Number of merge layers needed to reach a single code.
   function automatic int tree_levels(int pairs);
      int n;
      int lv;
      n  = pairs;
      lv = 0;
      while (n > 1) begin
         n  = (n + 1) / 2;
         lv = lv + 1;
      end
      return lv;
   endfunction

endpackage

// File: rtl/div3_pair_split.sv
module div3_pair_split
   import div3_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int PAIRS = (WIDTH + 1) / 2,
   localparam int EXT   = 2 * PAIRS
) (
   input  logic [WIDTH-1:0] din,
   output res_t             pair [PAIRS]
);

   logic [EXT-1:0] padded;

   if (EXT != WIDTH) begin : g_odd
      assign padded = {1'b0, din};
   end else begin : g_even
      assign padded = din;
   end

   for (genvar j = 0; j < PAIRS; j++) begin : g_pair
      assign pair[j].h = padded[2*j+1];
      assign pair[j].l = padded[2*j];
   end

endmodule

// File: rtl/div3_norm.sv
module div3_norm
   import div3_pkg::*;
(
   input  res_t code,
   output hot_t hot
);

   always_comb begin
      hot.one = code.l & ~code.h;
      hot.two = code.h & ~code.l;
   end

endmodule

// File: rtl/div3_combine.sv
module div3_combine
   import div3_pkg::*;
(
   input  res_t a,
   input  res_t b,
   output res_t y
);

   hot_t ha;
   hot_t hb;

   div3_norm u_norm_a (.code(a), .hot(ha));
   div3_norm u_norm_b (.code(b), .hot(hb));

   always_comb begin
      y.l = (ha.two & hb.two) | (ha.one ^ hb.one);
      y.h = (ha.one & hb.one) | (ha.two ^ hb.two);
   end

endmodule

// File: rtl/div3_tree.sv
module div3_tree
   import div3_pkg::*;
#(
   parameter int PAIRS = 16,
   localparam int LEVELS = tree_levels(PAIRS)
) (
   input  res_t leaf [PAIRS],
   output res_t root
);

   if (PAIRS < 1) begin : g_bad_pairs
      $error("div3_tree: PAIRS must be at least 1");
   end

   for (genvar k = 0; k <= LEVELS; k++) begin : g_lvl
      localparam int CNT = layer_count(PAIRS, k);
      res_t node [CNT];

      if (k == 0) begin : g_leaf
         for (genvar j = 0; j < CNT; j++) begin : g_cp
            assign node[j] = leaf[j];
         end
      end else begin : g_merge
         localparam int PREV = layer_count(PAIRS, k - 1);
         for (genvar j = 0; j < CNT; j++) begin : g_node
            if (2*j + 1 < PREV) begin : g_add
               div3_combine u_add (
                  .a(g_lvl[k-1].node[2*j]),
                  .b(g_lvl[k-1].node[2*j+1]),
                  .y(node[j])
               );
            end else begin : g_pass
               assign node[j] = g_lvl[k-1].node[2*j];
            end
         end
      end
   end

   assign root = g_lvl[LEVELS].node[0];

endmodule

// File: rtl/div3_verdict.sv
module div3_verdict
   import div3_pkg::*;
(
   input  res_t code,
   output logic zero_rem
);

   assign zero_rem = ~(code.h ^ code.l);

endmodule

// File: rtl/div3_detect.sv
module div3_detect
   import div3_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int PAIRS = (WIDTH + 1) / 2
) (
   input  logic [WIDTH-1:0] din,
   output logic             is_multiple
);

   if (WIDTH < 1) begin : g_bad_width
      $error("div3_detect: WIDTH must be at least 1");
   end

   res_t pair [PAIRS];
   res_t root;

   div3_pair_split #(.WIDTH(WIDTH)) u_split (
      .din (din),
      .pair(pair)
   );

   div3_tree #(.PAIRS(PAIRS)) u_tree (
      .leaf(pair),
      .root(root)
   );

   div3_verdict u_verdict (
      .code    (root),
      .zero_rem(is_multiple)
   );

endmodule

// File: rtl/div3_detect_chk.sv
module div3_detect_chk #(
   parameter int WIDTH = 32,
   localparam int EW = (WIDTH < 2) ? 2 : WIDTH
) (
   input logic [WIDTH-1:0] din,
   input logic             is_multiple,
   input logic             root_h,
   input logic             root_l
);

   logic [EW-1:0] ext;
   logic [1:0]    rem;

   always_comb begin
      ext = EW'(din);
      rem = 2'(ext % EW'(3));
   end

   // R1: verdict follows the arithmetic remainder
   always_comb begin
      assert_verdict_R1: assert (is_multiple == (rem == 2'd0))
         else $error("R1 verdict mismatch din=%0h", din);
   end

   // R2: final residue code encodes din mod 3
   always_comb begin
      assert_root_code_R2: assert (((root_h == root_l) == (rem == 2'd0)) &&
                                   ((root_l & ~root_h) == (rem == 2'd1)) &&
                                   ((root_h & ~root_l) == (rem == 2'd2)))
         else $error("R2 root code mismatch din=%0h", din);
   end

   // R4: all-zero input is a multiple
   always_comb begin
      assert_zero_input_R4: assert (!(din == '0) || is_multiple)
         else $error("R4 zero input not flagged");
   end

   // R6: all-ones input depends on width parity
   always_comb begin
      assert_all_ones_R6: assert (!(&din) || (is_multiple == ((WIDTH % 2) == 0)))
         else $error("R6 all-ones verdict wrong");
   end

   // R5: single-bit width inverts the bit
   if (WIDTH == 1) begin : g_one_bit
      always_comb begin
         assert_single_bit_R5: assert (is_multiple == ~din[0])
            else $error("R5 single-bit verdict wrong");
      end
   end

endmodule

bind div3_detect div3_detect_chk #(.WIDTH(WIDTH)) u_chk (
   .din        (din),
   .is_multiple(is_multiple),
   .root_h     (root.h),
   .root_l     (root.l)
);

// File: tb/div3_detect_test.sv
`timescale 1ns/1ps
module div3_detect_test;

   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [11:0] d12 = '0;  logic f12;
   logic [0:0]  d1  = '0;  logic f1;
   logic [1:0]  d2  = '0;  logic f2;
   logic [4:0]  d5  = '0;  logic f5;
   logic [6:0]  d7  = '0;  logic f7;
   logic [31:0] d32 = '0;  logic f32;
   logic [32:0] d33 = '0;  logic f33;
   logic [63:0] d64 = '0;  logic f64;

   div3_detect #(.WIDTH(12)) uut   (.din(d12), .is_multiple(f12));
   div3_detect #(.WIDTH(1))  u_w1  (.din(d1),  .is_multiple(f1));
   div3_detect #(.WIDTH(2))  u_w2  (.din(d2),  .is_multiple(f2));
   div3_detect #(.WIDTH(5))  u_w5  (.din(d5),  .is_multiple(f5));
   div3_detect #(.WIDTH(7))  u_w7  (.din(d7),  .is_multiple(f7));
   div3_detect #(.WIDTH(32)) u_w32 (.din(d32), .is_multiple(f32));
   div3_detect #(.WIDTH(33)) u_w33 (.din(d33), .is_multiple(f33));
   div3_detect #(.WIDTH(64)) u_w64 (.din(d64), .is_multiple(f64));

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic check(input string req, input int width,
                        input longint unsigned value, input logic got);
      logic exp;
      exp = ((value % 64'd3) == 64'd0);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s width=%0d value=%0h actual=%0b expected=%0b",
                  req, width, value, got, exp);
      end
   endtask

   task automatic expect_bit(input string req, input int width,
                             input longint unsigned value, input logic got,
                             input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s width=%0d value=%0h actual=%0b expected=%0b",
                  req, width, value, got, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= WATCHDOG && !done) begin
         errors++;
         $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: reset-state inputs are all zero, every width flags a multiple
      expect_bit("R4 zero w12", 12, 0, f12, 1'b1);
      expect_bit("R4 zero w1",  1,  0, f1,  1'b1);
      expect_bit("R4 zero w5",  5,  0, f5,  1'b1);
      expect_bit("R4 zero w33", 33, 0, f33, 1'b1);
      expect_bit("R4 zero w64", 64, 0, f64, 1'b1);

      // R5: single-bit width
      for (int v = 0; v < 2; v++) begin
         @(posedge clk); d1 = 1'(v);
         @(negedge clk);
         expect_bit("R5 single bit", 1, longint'(v), f1, ~1'(v));
      end

      // R2: one base-four digit
      for (int v = 0; v < 4; v++) begin
         @(posedge clk); d2 = 2'(v);
         @(negedge clk);
         expect_bit("R2 digit code", 2, longint'(v), f2, (v == 0 || v == 3));
      end

      // R3 / R7: odd widths, leftover codes, exhaustive
      for (int v = 0; v < 32; v++) begin
         @(posedge clk); d5 = 5'(v);
         @(negedge clk);
         check("R3 R7 width5 sweep", 5, longint'(v), f5);
      end
      for (int v = 0; v < 128; v++) begin
         @(posedge clk); d7 = 7'(v);
         @(negedge clk);
         check("R3 width7 sweep", 7, longint'(v), f7);
      end
      @(posedge clk); d5 = 5'd16;
      @(negedge clk);
      expect_bit("R3 top bit only", 5, 16, f5, 1'b0);
      @(posedge clk); d5 = 5'd24;
      @(negedge clk);
      expect_bit("R3 top pair plus digit", 5, 24, f5, 1'b1);

      // R1 / R7: width 12, six groups, exhaustive
      for (int v = 0; v < 4096; v++) begin
         @(posedge clk); d12 = 12'(v);
         @(negedge clk);
         check("R1 R7 width12 sweep", 12, longint'(v), f12);
      end

      // R1: random wide words
      for (int i = 0; i < 400; i++) begin
         longint unsigned v;
         v = {$urandom(), $urandom()};
         @(posedge clk);
         d32 = v[31:0];
         d33 = v[32:0];
         d64 = v;
         @(negedge clk);
         check("R1 random w32", 32, {32'd0, v[31:0]}, f32);
         check("R7 random w33", 33, {31'd0, v[32:0]}, f33);
         check("R1 random w64", 64, v, f64);
      end

      // R6: all ones
      @(posedge clk);
      d12 = '1; d5 = '1; d7 = '1; d32 = '1; d33 = '1; d64 = '1; d1 = '1; d2 = '1;
      @(negedge clk);
      expect_bit("R6 ones w12", 12, 64'hfff, f12, 1'b1);
      expect_bit("R6 ones w5",  5,  64'h1f,  f5,  1'b0);
      expect_bit("R6 ones w7",  7,  64'h7f,  f7,  1'b0);
      expect_bit("R6 ones w32", 32, 64'hffffffff, f32, 1'b1);
      expect_bit("R6 ones w33", 33, 64'h1ffffffff, f33, 1'b0);
      expect_bit("R6 ones w64", 64, 64'hffffffffffffffff, f64, 1'b1);
      expect_bit("R6 ones w1",  1,  1, f1, 1'b0);
      expect_bit("R6 ones w2",  2,  3, f2, 1'b1);

      // R8: settles without a clock edge
      @(negedge clk);
      d12 = 12'd9;
      #0.5;
      check("R8 no clock w12 value 9", 12, 9, f12);
      d12 = 12'd10;
      #0.5;
      check("R8 no clock w12 value 10", 12, 10, f12);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule